// File: doc/BRIEF.md
# Iterative Aligned-Subtract Unsigned Divider

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor over several clock cycles. It returns an N-bit quotient and an N-bit remainder. The dividend arrives as two N-bit halves. The upper half becomes the first partial remainder. The lower half is then pulled in one bit at a time, most significant bit first, by a chain of divide steps.

Each step does two things. First, while the partial remainder is smaller than the divisor, it shifts in further dividend bits and shifts the quotient along with them. A long run of zero quotient bits therefore costs no extra cycles. Second, it lines the divisor's top set bit up with the partial remainder's top set bit and backs off one place if that overshoots. It then subtracts, and adds the matching power of two to the quotient.

Several steps are chained in each clock cycle: four when N is 16 or more, and two when N is 8. A caller pulses start with the operands and then waits for either a one-cycle done pulse or a one-cycle error pulse. The results stay on the outputs until the next division completes.

Top module: `align_sub_divider`

## Requirements
- R1: After reset, busy_o, done_o, dz_err_o and ovf_err_o are 0, and quo_o and rem_o are 0.
- R2: For a division that completes, quo_o and rem_o satisfy {dvd_hi_i, dvd_lo_i} = quo_o * dvs_i + rem_o with rem_o < dvs_i. The operands are those sampled at the accepting edge.
- R3: A start with dvs_i = 0 raises dz_err_o for exactly one cycle, on the edge that samples it. busy_o and done_o stay 0, and quo_o and rem_o keep their previous values.
- R4: A start with a nonzero divisor and dvd_hi_i >= dvs_i raises ovf_err_o for one cycle on the sampling edge, with no busy, no done and no change of quo_o and rem_o. When the divisor is zero, only dz_err_o rises.
- R5: After an accepted start, busy_o is high from the accepting edge until the finishing edge. On that finishing edge done_o rises for exactly one cycle and busy_o falls.
- R6: A start asserted while busy_o is high is ignored. The running division completes with its own operands, and no additional done or error pulse follows.
- R7: quo_o and rem_o change only on the edge that raises done_o. They hold their values through idle cycles and error pulses.
- R8: done_o rises no later than ceil(N/S) edges after the accepting edge, where S is 4 for N >= 16 and 2 for N = 8.
- R9: When dvd_hi_i = 0 and dvd_lo_i < dvs_i, done_o rises on the first edge after the accepting edge, with quo_o = 0 and rem_o = dvd_lo_i.
- R10: A divide step entered with its remaining-bit counter at zero passes partial remainder, quotient and counter through unchanged. The final result does not depend on how many steps run after the counter reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a division; sampled only while idle |
| dvd_hi_i | input | N | Upper half of the dividend |
| dvd_lo_i | input | N | Lower half of the dividend |
| dvs_i | input | N | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| dz_err_o | output | 1 | One-cycle pulse for a zero divisor |
| ovf_err_o | output | 1 | One-cycle pulse when the quotient cannot fit in N bits |
| quo_o | output | N | Quotient of the last completed division |
| rem_o | output | N | Remainder of the last completed division |

## Verification
The bench targets the following corner cases, and each would be caught as described:

- **Counter running out in the middle of a cycle.** A dividend below the divisor drains all N bits in the first step. A design that let the later idle steps subtract or shift again would return a nonzero quotient or a late done.
- **Back-off after alignment.** The largest legal dividend over an all-ones divisor, and a divisor of 1, push the back-off and the one-bit-per-step worst case. A missing back-off gives a wrapped remainder, and a slow chain breaks the latency bound.
- **Error screening.** Zero divisors, with and without a large upper half, and upper halves equal to the divisor are applied. A design that screened these wrongly would raise the wrong pulse or overwrite the held result.
- **Start while busy.** A second start during a run is applied. A design that accepted it would corrupt the running quotient or produce an extra done.

// File: rtl/asdiv_pkg.sv
// Shared types and helpers for the aligned-subtract divider.
// Assumes: nothing beyond the standard language.
package asdiv_pkg;

    typedef enum logic {
        ASD_IDLE = 1'b0,
        ASD_RUN  = 1'b1
    } asd_state_e;

    // Number of chained divide steps per clock for a given operand width.
    function automatic int steps_for(input int n);
        return (n <= 8) ? 2 : 4;
    endfunction

endpackage

// File: rtl/asdiv_msb.sv
// Leading-one locator: returns the bit index of the highest set bit of v_i.
// Assumes: callers only use the result when v_i is nonzero (zero gives 0).
module asdiv_msb #(
    parameter int W  = 33,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  v_i,
    output logic [IW-1:0] pos_o
);

    // Scan upward so the last set bit found wins.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (v_i[i]) pos_o = IW'(i);
        end
    end

endmodule

// File: rtl/asdiv_step.sv
// One divide step, purely combinational.
// Phase 1 shifts dividend bits from the low half into the partial remainder
// while it is below the divisor. Phase 2 aligns the divisor's top bit with
// the remainder's top bit, backs off one place on overshoot, subtracts, and
// adds the matching quotient bit.
// Assumes: rem_i < dvs_i on entry, and dvs_i nonzero whenever cnt_i is nonzero.
// A zero counter makes the step a pass-through.
module asdiv_step #(
    parameter int N  = 32,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  rem_i,
    input  logic [N-1:0]  dvs_i,
    input  logic [N-1:0]  quo_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [N-1:0]  lo_i,
    output logic [N-1:0]  rem_o,
    output logic [N-1:0]  quo_o,
    output logic [CW-1:0] cnt_o
);

    localparam int W   = N + 1;
    localparam int IW  = $clog2(W);
    localparam int LIW = $clog2(N);

    logic [W-1:0]  dvs_ext;
    logic [W-1:0]  br_rem;
    logic [N-1:0]  br_quo;
    logic [CW-1:0] br_cnt;
    logic [IW-1:0] msb_rem;
    logic [IW-1:0] msb_dvs;
    logic [IW-1:0] shamt;
    logic [W-1:0]  al_dvs;
    logic [W-1:0]  qbit;
    logic [W-1:0]  rem_w;

    assign dvs_ext = {1'b0, dvs_i};

    // Phase 1: pull in low-half bits MSB-first while remainder < divisor.
    always_comb begin
        br_rem = {1'b0, rem_i};
        br_quo = quo_i;
        br_cnt = cnt_i;
        for (int i = 0; i < N; i++) begin
            if (br_rem < dvs_ext && br_cnt != '0) begin
                br_rem = {br_rem[W-2:0], lo_i[LIW'(br_cnt - CW'(1))]};
                br_quo = br_quo << 1;
                br_cnt = br_cnt - CW'(1);
            end
        end
    end

    asdiv_msb #(.W(W), .IW(IW)) u_msb_rem (.v_i(br_rem),  .pos_o(msb_rem));
    asdiv_msb #(.W(W), .IW(IW)) u_msb_dvs (.v_i(dvs_ext), .pos_o(msb_dvs));

    // Phase 2: aligned subtract with a one-place back-off on overshoot.
    always_comb begin
        shamt  = '0;
        al_dvs = '0;
        qbit   = '0;
        rem_w  = br_rem;
        quo_o  = br_quo;
        if (cnt_i != '0 && dvs_ext <= br_rem) begin
            shamt  = msb_rem - msb_dvs;
            al_dvs = dvs_ext << shamt;
            qbit   = W'(1) << shamt;
            if (al_dvs > br_rem) begin
                al_dvs = al_dvs >> 1;
                qbit   = qbit >> 1;
            end
            quo_o = br_quo + N'(qbit);
            rem_w = br_rem - al_dvs;
        end
        rem_o = N'(rem_w);
        cnt_o = br_cnt;
    end

endmodule

// File: rtl/asdiv_ctrl.sv
// Sequencer: screens each start for a zero divisor or quotient overflow,
// runs the step chain until the remaining-bit counter is exhausted, and
// emits one-cycle done and error pulses.
// Assumes: fin_i reflects the counter at the output of the last chained step.
module asdiv_ctrl
    import asdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dvs_zero_i,
    input  logic hi_ge_i,
    input  logic fin_i,
    output logic load_o,
    output logic commit_o,
    output logic busy_o,
    output logic done_o,
    output logic dz_o,
    output logic ovf_o
);

    asd_state_e state_q;
    logic       idle_start;

    assign idle_start = (state_q == ASD_IDLE) && start_i;
    assign load_o     = idle_start && !dvs_zero_i && !hi_ge_i;
    assign commit_o   = (state_q == ASD_RUN) && fin_i;
    assign busy_o     = (state_q == ASD_RUN);

    // State register and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ASD_IDLE;
            done_o  <= 1'b0;
            dz_o    <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            done_o <= commit_o;
            dz_o   <= idle_start && dvs_zero_i;
            ovf_o  <= idle_start && !dvs_zero_i && hi_ge_i;
            if (load_o)        state_q <= ASD_RUN;
            else if (commit_o) state_q <= ASD_IDLE;
        end
    end

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R3
    dz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> (!busy_o && !done_o && !ovf_o));

    // R4
    ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (!busy_o && !done_o));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fin_i) |=> busy_o);

endmodule

// File: rtl/align_sub_divider.sv
// Multi-cycle unsigned divider: {dvd_hi_i, dvd_lo_i} / dvs_i.
// Holds a working partial remainder, divisor, quotient and remaining-bit
// counter, and advances them through a chain of S divide steps per clock.
// Completed results are copied into output registers and held there.
// Assumes: N is one of 8, 16, 32, 64.
module align_sub_divider #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] dvd_hi_i,
    input  logic [N-1:0] dvd_lo_i,
    input  logic [N-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         dz_err_o,
    output logic         ovf_err_o,
    output logic [N-1:0] quo_o,
    output logic [N-1:0] rem_o
);

    localparam int S  = asdiv_pkg::steps_for(N);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  w_rem, w_dvs, w_quo, w_lo;
    logic [CW-1:0] w_cnt;
    logic          load, commit;

    logic [N-1:0]  ch_rem [0:S];
    logic [N-1:0]  ch_quo [0:S];
    logic [CW-1:0] ch_cnt [0:S];

    assign ch_rem[0] = w_rem;
    assign ch_quo[0] = w_quo;
    assign ch_cnt[0] = w_cnt;

    // S chained steps evaluated in one cycle.
    for (genvar k = 0; k < S; k++) begin : g_step
        asdiv_step #(.N(N), .CW(CW)) u_step (
            .rem_i (ch_rem[k]),
            .dvs_i (w_dvs),
            .quo_i (ch_quo[k]),
            .cnt_i (ch_cnt[k]),
            .lo_i  (w_lo),
            .rem_o (ch_rem[k+1]),
            .quo_o (ch_quo[k+1]),
            .cnt_o (ch_cnt[k+1])
        );

        // R10
        idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_cnt[k] == '0) |-> (ch_rem[k+1] == ch_rem[k] &&
                                   ch_quo[k+1] == ch_quo[k] &&
                                   ch_cnt[k+1] == '0));

        // R2
        rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o && ch_cnt[k] != '0) |-> (ch_rem[k+1] < w_dvs));
    end

    asdiv_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dvs_zero_i (dvs_i == '0),
        .hi_ge_i    (dvd_hi_i >= dvs_i),
        .fin_i      (ch_cnt[S] == '0),
        .load_o     (load),
        .commit_o   (commit),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .dz_o       (dz_err_o),
        .ovf_o      (ovf_err_o)
    );

    // Working state: load on accepted start, advance through the chain while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_rem <= '0;
            w_dvs <= '0;
            w_quo <= '0;
            w_lo  <= '0;
            w_cnt <= '0;
        end else if (load) begin
            w_rem <= dvd_hi_i;
            w_dvs <= dvs_i;
            w_quo <= '0;
            w_lo  <= dvd_lo_i;
            w_cnt <= CW'(N);
        end else if (busy_o) begin
            w_rem <= ch_rem[S];
            w_quo <= ch_quo[S];
            w_cnt <= ch_cnt[S];
        end
    end

    // Result registers: written only when a run finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_o <= '0;
            rem_o <= '0;
        end else if (commit) begin
            quo_o <= ch_quo[S];
            rem_o <= ch_rem[S];
        end
    end

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quo_o) && $stable(rem_o)));

    // R5
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !commit) |=> (busy_o && $stable(w_dvs)));

endmodule

// File: tb/sim_align_sub_divider.sv
module sim_align_sub_divider;

    localparam int N      = 32;
    localparam int S      = 4;
    localparam int MAXLAT = (N + S - 1) / S;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N-1:0]  dvd_hi_i = '0, dvd_lo_i = '0, dvs_i = '0;
    logic          busy_o, done_o, dz_err_o, ovf_err_o;
    logic [N-1:0]  quo_o, rem_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int           kind;   // 0 done, 1 zero divisor, 2 overflow
        logic [N-1:0] q;
        logic [N-1:0] r;
    } exp_t;

    exp_t         sb[$];
    logic [N-1:0] last_q = '0, last_r = '0;
    logic [N-1:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    align_sub_divider #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
        .busy_o(busy_o), .done_o(done_o), .dz_err_o(dz_err_o),
        .ovf_err_o(ovf_err_o), .quo_o(quo_o), .rem_o(rem_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: compute the expected item, push it, then issue one start.
    task automatic run_op(input logic [N-1:0] hi, input logic [N-1:0] lo,
                          input logic [N-1:0] d, output int lat);
        exp_t        e;
        logic [63:0] dvd;
        if (d == '0) begin
            e.kind = 1; e.q = last_q; e.r = last_r;
        end else if (hi >= d) begin
            e.kind = 2; e.q = last_q; e.r = last_r;
        end else begin
            dvd    = {hi, lo};
            e.kind = 0;
            e.q    = N'(dvd / {32'h0, d});
            e.r    = N'(dvd % {32'h0, d});
            last_q = e.q; last_r = e.r;
        end
        sb.push_back(e);
        @(negedge clk);
        dvd_hi_i = hi; dvd_lo_i = lo; dvs_i = d; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        if (e.kind == 0)
            check(busy_o == 1'b1 || done_o == 1'b1, "R5", "busy after accept", busy_o, 1);
        else
            check(busy_o == 1'b0, e.kind == 1 ? "R3" : "R4", "no busy on error", busy_o, 0);
        lat = 0;
        while (!(done_o || dz_err_o || ovf_err_o) && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        if (e.kind == 0)
            check(lat <= MAXLAT, "R8", "latency bound", lat, MAXLAT);
        else
            check(lat == 0, e.kind == 1 ? "R3" : "R4", "error pulse timing", lat, 0);
    endtask

    // Monitor: pop one expected item per event and compare.
    always @(negedge clk) begin
        if (rst_n && (done_o || dz_err_o || ovf_err_o)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected completion event", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(done_o == (e.kind == 0), "R5", "done pulse", done_o, e.kind == 0);
                check(dz_err_o == (e.kind == 1), "R3", "zero-divisor pulse", dz_err_o, e.kind == 1);
                check(ovf_err_o == (e.kind == 2), "R4", "overflow pulse", ovf_err_o, e.kind == 2);
                check(quo_o == e.q, e.kind == 0 ? "R2" : "R7", "quotient", quo_o, e.q);
                check(rem_o == e.r, e.kind == 0 ? "R2" : "R7", "remainder", rem_o, e.r);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            check(1'b0, "R5", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0 && done_o == 0, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        check(dz_err_o == 0 && ovf_err_o == 0, "R1", "errors after reset", {dz_err_o, ovf_err_o}, 0);
        check(quo_o == 0 && rem_o == 0, "R1", "results after reset", quo_o, 0);

        // R2 small division
        run_op(32'd0, 32'd100, 32'd7, lat);
        // R9 / R10: dividend below divisor drains all bits in the first step
        run_op(32'd0, 32'd5, 32'd9, lat);
        check(lat == 1, "R9", "early finish latency", lat, 1);
        check(quo_o == 0 && rem_o == 5, "R10", "idle steps leave result intact", rem_o, 5);
        // R2 largest legal dividend over all-ones divisor (back-off path)
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
        // R8 worst case: one quotient bit per step
        run_op(32'd0, 32'hFFFF_FFFF, 32'd1, lat);
        check(lat == MAXLAT, "R8", "worst-case latency", lat, MAXLAT);
        run_op(32'h0001_2345, 32'h89AB_CDEF, 32'h8000_0000, lat);

        // R3 zero divisor, and priority over overflow
        run_op(32'd3, 32'd4, 32'd0, lat);
        run_op(32'hFFFF_FFFF, 32'd4, 32'd0, lat);
        // R4 overflow at equality and above
        run_op(32'd10, 32'd0, 32'd10, lat);
        run_op(32'd11, 32'd0, 32'd10, lat);

        // R7 hold through idle cycles
        repeat (6) @(negedge clk);
        check(quo_o == last_q && rem_o == last_r, "R7", "held result", quo_o, last_q);

        // R6 start during a run is ignored
        begin
            exp_t e;
            e.kind = 0; e.q = 32'hFFFF_FFFF; e.r = 32'd0;
            last_q = e.q; last_r = e.r;
            sb.push_back(e);
            @(negedge clk);
            dvd_hi_i = 0; dvd_lo_i = 32'hFFFF_FFFF; dvs_i = 32'd1; start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            dvd_hi_i = 0; dvd_lo_i = 32'd9; dvs_i = 32'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o == 1'b1, "R6", "still busy after ignored start", busy_o, 1);
            while (!done_o) @(negedge clk);
            check(quo_o == 32'hFFFF_FFFF, "R6", "first operands kept", quo_o, 32'hFFFF_FFFF);
            repeat (12) @(negedge clk);
            check(sb.size() == 0, "R6", "no extra events", sb.size(), 0);
        end

        // R2 pseudo-random operands
        for (int i = 0; i < 60; i++) begin
            logic [N-1:0] d, hi, lo;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            d   = (i % 3 == 0) ? (lcg >> (i % 29)) | 32'd1 : lcg | 32'd1;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            hi  = lcg % d;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            lo  = lcg;
            run_op(hi, lo, d, lat);
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule